// File: doc/BRIEF.md
# Two-Class Prioritised Interrupt Vector Arbiter

This block sits between a bank of already-captured interrupt lines and a processor that has two interrupt inputs. One is the normal request and the other is the fast request. Each line carries four things: a pending bit, a mask bit, a class bit and a small priority number. For each class the arbiter picks one winning line. It latches that line's number as the active vector for the class and raises the class's request output.

Once a class has raised its output, it is disarmed. Its vector is frozen until software acknowledges that class. The acknowledge drops the class's request, re-arms it and re-arbitrates in the same clock. If another eligible line is waiting, the request therefore stays up and carries the new vector on the next edge.

Up to three banks of 32 lines are supported. A line's global number is its bank times 32 plus its bit position, so the global number is simply its bit index on the line ports. Line capture and register decode stay outside the block. A single gate input stands in for the global enable.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Line i is eligible for a class when `line_pend_i[i]`=1, `line_mask_i[i]`=0, and `line_fiq_i[i]` equals the class (1 selects the fast class, 0 the normal class). A masked line, or a line of the other class, never wins.
- R2: Among the eligible lines of a class, the smallest priority number wins, and 0 is the most urgent. The priority of line i is `line_prio_i[i*PRIO_W +: PRIO_W]`.
- R3: When several eligible lines share the best priority, the one with the highest index wins.
- R4: The vector equals 32 × bank + bit position, which is the line's bit index on the line ports. Line 95 therefore gives vector 95.
- R5: An armed class raises its request at the next clock edge when it has at least one eligible line and `gate_open_i`=1. The vector latched at that edge is the winner. While `gate_open_i`=0 nothing is raised.
- R6: While a request is high and its class is not acknowledged, both the request and its vector hold. This is true even when more urgent lines arrive or the winning line is masked or withdrawn.
- R7: An acknowledge (`ack_i` bit 0 for normal, bit 1 for fast) re-arbitrates that class at the next edge. If an eligible line exists and the gate is open, the request stays or goes high with the new winner. Otherwise the request goes low, the vector keeps its old value and the class is left armed.
- R8: During reset and after it, both requests are low, both vectors are 0 and both classes are armed.
- R9: Clearing a mask bit of a pending line re-arbitrates an armed class, which raises at the next edge.
- R10: Acknowledging one class leaves the other class's request and vector untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pend_i | input | NUM_BANKS*32 | Captured pending bit per line |
| line_mask_i | input | NUM_BANKS*32 | Per-line mask, 1 blocks the line |
| line_fiq_i | input | NUM_BANKS*32 | Per-line class, 1 = fast, 0 = normal |
| line_prio_i | input | NUM_BANKS*32*PRIO_W | Per-line priority number, 0 most urgent |
| gate_open_i | input | 1 | Global enable, 0 holds back new requests |
| ack_i | input | 2 | Acknowledge pulse, bit 0 normal, bit 1 fast |
| irq_req_o | output | 1 | Normal-class request |
| irq_vec_o | output | VEC_W | Latched normal-class vector |
| fiq_req_o | output | 1 | Fast-class request |
| fiq_vec_o | output | VEC_W | Latched fast-class vector |

## Verification
The bench goes after the tie rule by pending three lines of equal priority in different banks. A design that scanned the wrong way would report the lowest one. It checks that a raised vector stays frozen when a more urgent line arrives or the winner is masked. An arbiter that tracked the live winner would change the vector under the processor. It acknowledges with nothing eligible and with the gate closed, where a design that kept the request up would interrupt endlessly. It also acknowledges only one class to catch designs that disturb the other.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

   localparam int unsigned LINES_PER_BANK = 32;

   typedef enum logic {
      CLS_NORMAL = 1'b0,
      CLS_FAST   = 1'b1
   } irq_class_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irqarb_select.sv
// Picks the most urgent eligible line; ties go to the higher index.
module irqarb_select #(
   parameter int unsigned N        = 96,
   parameter int unsigned PW       = 6,
   parameter int unsigned IW       = 7,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [N-1:0]    elig_i,
   input  logic [N*PW-1:0] prio_i,
   output logic            valid_o,
   output logic [IW-1:0]   idx_o
);

   if (IW < $clog2(N)) begin : g_bad_iw
      $error("irqarb_select: IW too narrow for N");
   end

   if (USE_TREE) begin : g_tree
      localparam int unsigned LG = (N > 1) ? $clog2(N) : 0;
      localparam int unsigned P  = 1 << LG;

      for (genvar l = 0; l <= LG; l++) begin : lv
         localparam int unsigned W = P >> l;
         logic [W-1:0]  v;
         logic [PW-1:0] p  [W];
         logic [IW-1:0] ix [W];

         if (l == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_in
               if (i < N) begin : g_real
                  assign v[i]  = elig_i[i];
                  assign p[i]  = prio_i[i*PW +: PW];
                  assign ix[i] = IW'(i);
               end else begin : g_pad
                  assign v[i]  = 1'b0;
                  assign p[i]  = '0;
                  assign ix[i] = '0;
               end
            end
         end else begin : g_join
            for (genvar k = 0; k < W; k++) begin : g_nd
               logic take_hi;
               assign take_hi = lv[l-1].v[2*k+1] &&
                                (!lv[l-1].v[2*k] ||
                                 (lv[l-1].p[2*k+1] <= lv[l-1].p[2*k]));
               assign v[k]  = lv[l-1].v[2*k] | lv[l-1].v[2*k+1];
               assign p[k]  = take_hi ? lv[l-1].p[2*k+1]  : lv[l-1].p[2*k];
               assign ix[k] = take_hi ? lv[l-1].ix[2*k+1] : lv[l-1].ix[2*k];
            end
         end
      end

      assign valid_o = lv[LG].v[0];
      assign idx_o   = lv[LG].ix[0];
   end else begin : g_scan
      logic [PW-1:0] best_p;
      always_comb begin
         valid_o = 1'b0;
         best_p  = '0;
         idx_o   = '0;
         for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (!valid_o || (prio_i[i*PW +: PW] <= best_p))) begin
               valid_o = 1'b1;
               best_p  = prio_i[i*PW +: PW];
               idx_o   = IW'(i);
            end
         end
      end
   end

endmodule

// File: rtl/irqarb_class.sv
// Request/vector state of one class. The class is armed whenever req_o is low.
module irqarb_class #(
   parameter int unsigned IW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cand_valid_i,
   input  logic [IW-1:0] cand_idx_i,
   input  logic          gate_open_i,
   input  logic          ack_i,
   output logic          req_o,
   output logic [IW-1:0] vec_o
);

   logic fire;
   assign fire = cand_valid_i & gate_open_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o <= 1'b0;
         vec_o <= '0;
      end else if (ack_i) begin
         // drop, re-arm and re-arbitrate within the same edge
         req_o <= fire;
         if (fire) vec_o <= cand_idx_i;
      end else if (!req_o && fire) begin
         req_o <= 1'b1;
         vec_o <= cand_idx_i;
      end
   end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
   import irqarb_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned PRIO_W    = 6,
   parameter bit          USE_TREE  = 1'b1,
   localparam int unsigned LINES    = NUM_BANKS * LINES_PER_BANK,
   localparam int unsigned VEC_W    = idx_width(LINES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LINES-1:0]        line_pend_i,
   input  logic [LINES-1:0]        line_mask_i,
   input  logic [LINES-1:0]        line_fiq_i,
   input  logic [LINES*PRIO_W-1:0] line_prio_i,
   input  logic                    gate_open_i,
   input  logic [1:0]              ack_i,
   output logic                    irq_req_o,
   output logic [VEC_W-1:0]        irq_vec_o,
   output logic                    fiq_req_o,
   output logic [VEC_W-1:0]        fiq_vec_o
);

   if (NUM_BANKS < 1 || NUM_BANKS > 3) begin : g_bad_banks
      $error("irq_vector_arbiter: NUM_BANKS must be 1..3");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("irq_vector_arbiter: PRIO_W must be 1..8");
   end

   logic [1:0]       req;
   logic [VEC_W-1:0] vec [2];

   for (genvar c = 0; c < 2; c++) begin : g_cls
      localparam irq_class_e CLS = (c == 0) ? CLS_NORMAL : CLS_FAST;
      logic [LINES-1:0] elig;
      logic             cand_v;
      logic [VEC_W-1:0] cand_i;

      assign elig = line_pend_i & ~line_mask_i &
                    ((CLS == CLS_FAST) ? line_fiq_i : ~line_fiq_i);

      irqarb_select #(
         .N        (LINES),
         .PW       (PRIO_W),
         .IW       (VEC_W),
         .USE_TREE (USE_TREE)
      ) sel_i (
         .elig_i  (elig),
         .prio_i  (line_prio_i),
         .valid_o (cand_v),
         .idx_o   (cand_i)
      );

      irqarb_class #(.IW(VEC_W)) st_i (
         .clk          (clk),
         .rst_n        (rst_n),
         .cand_valid_i (cand_v),
         .cand_idx_i   (cand_i),
         .gate_open_i  (gate_open_i),
         .ack_i        (ack_i[c]),
         .req_o        (req[c]),
         .vec_o        (vec[c])
      );
   end

   assign irq_req_o = req[0];
   assign irq_vec_o = vec[0];
   assign fiq_req_o = req[1];
   assign fiq_vec_o = vec[1];

endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk #(
   parameter int unsigned LINES = 96,
   parameter int unsigned VEC_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LINES-1:0] line_pend_i,
   input logic [LINES-1:0] line_mask_i,
   input logic [LINES-1:0] line_fiq_i,
   input logic             gate_open_i,
   input logic [1:0]       ack_i,
   input logic             irq_req_o,
   input logic [VEC_W-1:0] irq_vec_o,
   input logic             fiq_req_o,
   input logic [VEC_W-1:0] fiq_vec_o
);

   logic [LINES-1:0] e_irq, e_fiq, e_irq_q, e_fiq_q;
   logic             go_irq, go_fiq;

   assign e_irq  = line_pend_i & ~line_mask_i & ~line_fiq_i;
   assign e_fiq  = line_pend_i & ~line_mask_i &  line_fiq_i;
   assign go_irq = (|e_irq) & gate_open_i;
   assign go_fiq = (|e_fiq) & gate_open_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_irq_q <= '0;
         e_fiq_q <= '0;
      end else begin
         e_irq_q <= e_irq;
         e_fiq_q <= e_fiq;
      end
   end

   assert_reset_state_R8: assert property (@(posedge clk)
      !rst_n |=> (!irq_req_o && !fiq_req_o && irq_vec_o == '0 && fiq_vec_o == '0));

   assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req_o && go_irq) |=> irq_req_o);

   assert_fiq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fiq_req_o && go_fiq) |=> fiq_req_o);

   assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_o && !ack_i[0]) |=> (irq_req_o && $stable(irq_vec_o)));

   assert_fiq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_req_o && !ack_i[1]) |=> (fiq_req_o && $stable(fiq_vec_o)));

   assert_irq_vec_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req_o) |-> e_irq_q[irq_vec_o]);

   assert_fiq_vec_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fiq_req_o) |-> e_fiq_q[fiq_vec_o]);

   assert_irq_ack_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[0] && !go_irq) |=> !irq_req_o);

   assert_fiq_ack_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[1] && !go_fiq) |=> !fiq_req_o);

endmodule

bind irq_vector_arbiter irqarb_chk #(
   .LINES (LINES),
   .VEC_W (VEC_W)
) chk_i (.*);

// File: tb/irq_vector_arbiter_tb_top.sv
module irq_vector_arbiter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 3;
   localparam int PW = 6;
   localparam int N  = NB * 32;
   localparam int VW = $clog2(N);
   localparam int EW = 2 * VW + 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [N-1:0]    pend, mask, fiqc;
   logic [N*PW-1:0] prio;
   logic            gate;
   logic [1:0]      ack;
   logic            irq_req, fiq_req;
   logic [VW-1:0]   irq_vec, fiq_vec;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_pend_i (pend),
      .line_mask_i (mask),
      .line_fiq_i  (fiqc),
      .line_prio_i (prio),
      .gate_open_i (gate),
      .ack_i       (ack),
      .irq_req_o   (irq_req),
      .irq_vec_o   (irq_vec),
      .fiq_req_o   (fiq_req),
      .fiq_vec_o   (fiq_vec)
   );

   // reference state
   logic          m_req [2];
   logic [VW-1:0] m_vec [2];

   logic [EW-1:0] exp_q [$];
   string         tag_q [$];
   int            n_chk  = 0;
   int            n_fail = 0;
   bit            finished = 1'b0;

   task automatic set_line(input int i, input int p, input bit fast);
      prio[i*PW +: PW] = PW'(p);
      fiqc[i] = fast;
   endtask

   // Driver: predicts the state after the coming edge, queues it, waits one cycle.
   task automatic tick(input string tag);
      for (int c = 0; c < 2; c++) begin
         bit          found = 1'b0;
         int          best  = 0;
         int          win   = 0;
         for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && !mask[i] && (fiqc[i] == c[0]) &&
                (!found || int'(prio[i*PW +: PW]) < best)) begin
               found = 1'b1;
               best  = int'(prio[i*PW +: PW]);
               win   = i;
            end
         end
         if (!rst_n) begin
            m_req[c] = 1'b0;
            m_vec[c] = '0;
         end else if (ack[c]) begin
            m_req[c] = found && gate;
            if (found && gate) m_vec[c] = VW'(win);
         end else if (!m_req[c] && found && gate) begin
            m_req[c] = 1'b1;
            m_vec[c] = VW'(win);
         end
      end
      exp_q.push_back({m_req[1], m_req[0], m_vec[1], m_vec[0]});
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic ack_tick(input logic [1:0] a, input string tag);
      ack = a;
      tick(tag);
      ack = 2'b00;
   endtask

   // Monitor: compares a quarter period after each rising edge.
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
         logic [EW-1:0] e;
         logic [EW-1:0] a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {fiq_req, irq_req, fiq_vec, irq_vec};
         n_chk++;
         if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual fiq=%0b irq=%0b fvec=%0d ivec=%0d expected fiq=%0b irq=%0b fvec=%0d ivec=%0d",
                     t, a[EW-1], a[EW-2], a[2*VW-1:VW], a[VW-1:0],
                     e[EW-1], e[EW-2], e[2*VW-1:VW], e[VW-1:0]);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      m_req[0] = 1'b0; m_req[1] = 1'b0;
      m_vec[0] = '0;   m_vec[1] = '0;
      rst_n = 1'b0;
      pend  = '0;
      mask  = '1;
      fiqc  = '0;
      prio  = '0;
      gate  = 1'b1;
      ack   = 2'b00;
      @(negedge clk);
      tick("R8 in reset");
      tick("R8 in reset");
      rst_n = 1'b1;
      tick("R8 idle after reset");

      // masked line stays out
      pend[5] = 1'b1;
      set_line(5, 10, 1'b0);
      tick("R1 masked line ignored");
      mask = '0;
      tick("R9 unmask raises");

      // more urgent arrival does not disturb the latched vector
      pend[60] = 1'b1;
      set_line(60, 0, 1'b0);
      tick("R6 vector held on urgent arrival");
      ack_tick(2'b01, "R2 ack picks smaller priority");
      pend[60] = 1'b0;
      ack_tick(2'b01, "R7 ack re-arbitrates remaining line");

      // ties across banks
      pend = '0;
      pend[3] = 1'b1;  set_line(3, 7, 1'b0);
      pend[40] = 1'b1; set_line(40, 7, 1'b0);
      pend[90] = 1'b1; set_line(90, 7, 1'b0);
      ack_tick(2'b01, "R3 tie goes to highest index");
      pend[95] = 1'b1; set_line(95, 1, 1'b0);
      ack_tick(2'b01, "R4 last line of bank 2");

      // fast class
      pend[70] = 1'b1; set_line(70, 0, 1'b1);
      tick("R1 fast class line");
      ack_tick(2'b10, "R10 fast ack leaves normal alone");

      // gate handling
      gate = 1'b0;
      pend = '0;
      ack_tick(2'b11, "R7 ack with nothing eligible");
      pend[12] = 1'b1; set_line(12, 3, 1'b0);
      tick("R5 gate closed blocks");
      gate = 1'b1;
      tick("R5 gate opens raises");
      mask[12] = 1'b1;
      tick("R6 masking winner does not retract");
      ack_tick(2'b01, "R7 ack after winner masked");
      mask[12] = 1'b0;
      tick("R9 unmask re-arbitrates");

      // mid-run reset
      rst_n = 1'b0;
      tick("R8 reset mid-run");
      rst_n = 1'b1;
      pend = '0;
      tick("R8 armed after reset");

      // sweep single lines across all banks, mixed classes
      for (int k = 0; k < 16; k++) begin
         pend = '0;
         pend[k*6] = 1'b1;
         set_line(k*6, (k * 5) % 64, k[0]);
         ack_tick(2'b11, "R4 single-line sweep");
      end

      // every line pending with scattered priorities
      for (int i = 0; i < N; i++) set_line(i, (i * 37 + 11) % 64, (i % 3) == 0);
      pend = '1;
      ack_tick(2'b11, "R2 full load scattered priorities");
      for (int i = 0; i < N; i++) set_line(i, (i * 13) % 5, (i % 2) == 1);
      ack_tick(2'b11, "R3 full load many ties");
      mask = {N{1'b1}} >> 20;
      ack_tick(2'b11, "R1 upper lines only");
      ack_tick(2'b00, "R6 no ack holds");

      pend = '0;
      ack = 2'b00;
      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule